// File: doc/BRIEF.md
# Key-Armed Watchdog with Reset-Out Pulse

This block is a watchdog for a small processor subsystem. It is idle after a hardware reset and does nothing until software writes a two-byte key to one write-only register address on the register write bus. The first complete key arms the watchdog. From then on a 14-bit counter advances on every cycle in which the machine-cycle enable is high. Each later complete key clears the counter. Software has no way to read the counter and no way to switch the watchdog off again. Only a hardware reset or the watchdog's own expiry disarms it.

When the counter is at its all-ones value and one more machine-cycle enable arrives, the block expires. It raises a one-clock internal reset request, disarms itself, and drives the reset pin high for a fixed number of oscillator clocks. A suppress input, sampled at the moment of expiry, blocks the pin drive but not the internal request.

There is no data stream here. Register writes arrive as single strobed cycles, and the block accepts every strobe with no back-pressure, so it needs no valid/ready handshake. All pins are plain control or status signals.

Top module: `wdt_unlock_top`

## Requirements
- R1: While reset is asserted, and afterwards until a key has been accepted, `wdt_reset_req` and `rst_pin_drive` stay low, whatever the machine-cycle enable does.
- R2: A write of 8'h1E to address 8'hA6 followed by a write of 8'hE1 to 8'hA6 arms the watchdog. Idle cycles with no strobe may separate the two writes.
- R3: A write of 8'hE1 that does not come directly after a 1Eh key write (counting only strobed writes) is ignored. Any write between the two key bytes cancels the pending key, whether it carries other data to 8'hA6 or goes to another address.
- R4: The counter advances only on clocks where `mc_tick` is high. If the key write is sampled at edge N and `mc_tick` stays high, `wdt_reset_req` is high after edge N+16384. Each low `mc_tick` clock delays this by one clock.
- R5: A complete key while the watchdog is armed clears the counter, so the next expiry is timed from that key.
- R6: While armed, writes that do not form a complete key (other values, a lone E1h, other addresses) do not disarm the watchdog and do not change when it expires.
- R7: `wdt_reset_req` is high for exactly one clock at each expiry. The expiry also disarms the watchdog, so no further expiry happens without a new key.
- R8: If `pin_drive_off` is low at the expiry clock, `rst_pin_drive` goes high in the same clock as `wdt_reset_req` and stays high for exactly 98 clocks.
- R9: If `pin_drive_off` is high at the expiry clock, `rst_pin_drive` stays low. `wdt_reset_req` still pulses.
- R10: A hardware reset while the watchdog is armed disarms it. No expiry follows unless a new key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| pin_drive_off | input | 1 | When high at expiry, the reset pin is not driven |
| wdt_reset_req | output | 1 | One-clock internal reset request at expiry |
| rst_pin_drive | output | 1 | Drive-high enable for the reset pin |

## Verification
The bound checker watches every cycle for the following: the request lasts a single clock, an expiry only happens on a clock that carries a machine-cycle enable, the pin pulse only starts together with a request, each pulse lasts exactly the configured length, and a suppressed expiry leaves the pin low. The properties do not express the key decoding or the 16384-tick timing, because each would need a full model of the block. The bench scenarios cover these instead: rejected and cancelled key sequences, re-keying while armed, gaps in the machine-cycle enable, disarm on expiry, and disarm on hardware reset. For each one the bench predicts the exact clock of the request, or confirms that no request comes.

// File: rtl/wdt_unlock_pkg.sv
package wdt_unlock_pkg;

  // Progress through the two-byte key
  typedef enum logic [0:0] {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;

  localparam int unsigned DEF_CNT_W     = 14;
  localparam int unsigned DEF_PULSE_LEN = 98;

  // Bits needed to hold the value v
  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_unlock_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 8,
  parameter int unsigned         DATA_W   = 8,
  parameter logic [ADDR_W-1:0]   SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0]   KEY_A    = 8'h1E,
  parameter logic [DATA_W-1:0]   KEY_B    = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              svc
);

  key_state_e state_q, state_d;
  logic       hit;

  assign hit = wr && (addr == SVC_ADDR);

  // The second byte counts only when the first byte was the latest write
  assign svc = hit && (wdata == KEY_B) && (state_q == KEY_HALF);

  always_comb begin
    state_d = state_q;
    if (flush) begin
      state_d = KEY_IDLE;
    end else if (wr) begin
      // Every strobed write either starts a new key or cancels the pending one
      state_d = (hit && (wdata == KEY_A)) ? KEY_HALF : KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/wdt_tick_count.sv
module wdt_tick_count #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc,
  input  logic tick,
  output logic expire
);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  // Expiry needs the last count value plus one more machine cycle
  assign expire = armed_q && tick && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (expire) begin
      // Expiry resets the device, so it takes priority over a same-cycle key
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (svc) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdt_pin_pulse.sv
module wdt_pin_pulse
  import wdt_unlock_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic suppress,
  output logic pin
);

  localparam int unsigned LEN_W = width_for(PULSE_LEN);

  logic [LEN_W-1:0] left_q;

  assign pin = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire && !suppress) begin
      left_q <= LEN_W'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - LEN_W'(1);
    end
  end

endmodule

// File: rtl/wdt_unlock_top.sv
module wdt_unlock_top
  import wdt_unlock_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A     = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B     = 8'hE1,
  parameter int unsigned       CNT_W     = DEF_CNT_W,
  parameter int unsigned       PULSE_LEN = DEF_PULSE_LEN
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pin_drive_off,
  output logic              wdt_reset_req,
  output logic              rst_pin_drive
);

  logic svc;
  logic expire;
  logic req_q;

  wdt_key_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SVC_ADDR(SVC_ADDR),
    .KEY_A   (KEY_A),
    .KEY_B   (KEY_B)
  ) key_i (
    .clk  (osc_clk),
    .rst_n(rst_n),
    .flush(expire),
    .wr   (bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .svc  (svc)
  );

  wdt_tick_count #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .svc   (svc),
    .tick  (mc_tick),
    .expire(expire)
  );

  wdt_pin_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) pulse_i (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .fire    (expire),
    .suppress(pin_drive_off),
    .pin     (rst_pin_drive)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= expire;
  end

  assign wdt_reset_req = req_q;

endmodule

// File: rtl/wdt_unlock_chk.sv
module wdt_unlock_chk #(
  parameter int unsigned PULSE_LEN = 98
) (
  input logic clk,
  input logic rst_n,
  input logic mc_tick,
  input logic pin_drive_off,
  input logic wdt_reset_req,
  input logic rst_pin_drive
);

  int unsigned run_q;

  // Clocks the pin has been high so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= 0;
    else if (rst_pin_drive) run_q <= run_q + 1;
    else                    run_q <= 0;
  end

  // R7
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  // R4
  req_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> $past(mc_tick));

  // R8
  pin_starts_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin_drive) |-> wdt_reset_req);

  // R8
  pin_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pin_drive) |-> (run_q == PULSE_LEN));

  // R9
  pin_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset_req && $past(pin_drive_off) && !$past(rst_pin_drive)) |-> !rst_pin_drive);

endmodule

bind wdt_unlock_top wdt_unlock_chk #(
  .PULSE_LEN(PULSE_LEN)
) chk_i (
  .clk          (osc_clk),
  .rst_n        (rst_n),
  .mc_tick      (mc_tick),
  .pin_drive_off(pin_drive_off),
  .wdt_reset_req(wdt_reset_req),
  .rst_pin_drive(rst_pin_drive)
);

// File: tb/wdt_unlock_top_tb_top.sv
`timescale 1ns/1ps
module wdt_unlock_top_tb_top;

  localparam int unsigned SPAN  = (1 << 14) + 1;
  localparam int unsigned PLEN  = 98;
  localparam int unsigned QUIET = 16500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       pin_drive_off = 1'b0;
  logic       wdt_reset_req;
  logic       rst_pin_drive;

  wdt_unlock_top dut_i (
    .osc_clk      (clk),
    .rst_n        (rst_n),
    .mc_tick      (mc_tick),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .pin_drive_off(pin_drive_off),
    .wdt_reset_req(wdt_reset_req),
    .rst_pin_drive(rst_pin_drive)
  );

  always #2 clk = ~clk;

  int unsigned pcyc = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  int    checks = 0;
  int    fails  = 0;
  string phase_tag = "R1";

  typedef struct {
    int unsigned at;
    int unsigned len;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Driver: one strobed write, returns the cycle count it was driven in
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, output int unsigned when);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; when = pcyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_key(input int unsigned gap, output int unsigned when);
    int unsigned t0;
    bus_write(8'hA6, 8'h1E, t0);
    idle(gap);
    bus_write(8'hA6, 8'hE1, when);
  endtask

  task automatic expect_expiry(input int unsigned at, input int unsigned len, input string tag);
    exp_t e;
    e.at = at; e.len = len; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    idle(PLEN + 10);
  endtask

  // Monitor: pops the expected expiries and compares timing and pulse shape
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wdt_reset_req) begin
        if (sb_q.size() == 0) begin
          check(1'b0, phase_tag, "unexpected reset request at cycle", pcyc, 0);
        end else begin
          exp_t        e;
          int unsigned len;
          bit          first;
          e = sb_q.pop_front();
          check(pcyc == e.at, e.tag, "reset request cycle", pcyc, e.at);
          len = 0;
          first = 1'b1;
          while (rst_pin_drive) begin
            len++;
            @(negedge clk);
            if (first) begin
              check(!wdt_reset_req, "R7", "request width beyond one clock", wdt_reset_req, 0);
              first = 1'b0;
            end
          end
          if (first) begin
            @(negedge clk);
            check(!wdt_reset_req, "R7", "request width beyond one clock", wdt_reset_req, 0);
          end
          check(len == e.len, (e.len == 0) ? "R9" : "R8", "pin pulse length", len, e.len);
        end
      end else if (rst_n && rst_pin_drive) begin
        check(1'b0, "R8", "pin high without request", 1, 0);
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish, cycle", pcyc, 195000);
    report();
  end

  initial begin
    int unsigned t, n;

    // R1: reset state
    idle(5);
    check(!wdt_reset_req && !rst_pin_drive, "R1", "outputs in reset",
          {wdt_reset_req, rst_pin_drive}, 0);
    rst_n = 1'b1;

    // R1, R3: lone E1h, broken keys; nothing may arm
    phase_tag = "R3";
    bus_write(8'hA6, 8'hE1, t);
    bus_write(8'hA6, 8'h1E, t);
    bus_write(8'hA6, 8'h55, t);
    bus_write(8'hA6, 8'hE1, t);
    bus_write(8'hA6, 8'h1E, t);
    bus_write(8'h20, 8'h00, t);
    bus_write(8'hA6, 8'hE1, t);
    idle(QUIET);
    check(!wdt_reset_req && !rst_pin_drive, "R3", "no expiry after rejected keys",
          {wdt_reset_req, rst_pin_drive}, 0);

    // R2, R6, R8: key with idle gap, then non-key writes while armed
    phase_tag = "R6";
    send_key(4, n);
    expect_expiry(n + SPAN, PLEN, "R2");
    idle(3000);
    bus_write(8'hA6, 8'h00, t);
    bus_write(8'hA6, 8'hFF, t);
    bus_write(8'hA6, 8'hE1, t);
    bus_write(8'h10, 8'h1E, t);
    drain();

    // R5: re-key while armed restarts the count
    phase_tag = "R5";
    send_key(0, n);
    idle(8000);
    send_key(0, n);
    expect_expiry(n + SPAN, PLEN, "R5");
    drain();

    // R4: machine-cycle enable held low for 500 clocks
    phase_tag = "R4";
    send_key(0, n);
    idle(100);
    @(negedge clk);
    mc_tick = 1'b0;
    idle(500);
    mc_tick = 1'b1;
    expect_expiry(n + SPAN + 500, PLEN, "R4");
    drain();

    // R9: pin drive suppressed
    phase_tag = "R9";
    pin_drive_off = 1'b1;
    send_key(2, n);
    expect_expiry(n + SPAN, 0, "R9");
    drain();
    pin_drive_off = 1'b0;

    // R7: disarmed after expiry
    phase_tag = "R7";
    idle(QUIET);
    check(!wdt_reset_req && !rst_pin_drive, "R7", "no second expiry without key",
          {wdt_reset_req, rst_pin_drive}, 0);

    // R10: hardware reset disarms
    phase_tag = "R10";
    send_key(0, n);
    idle(5000);
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    check(!wdt_reset_req && !rst_pin_drive, "R10", "outputs in mid-run reset",
          {wdt_reset_req, rst_pin_drive}, 0);
    rst_n = 1'b1;
    idle(QUIET);
    check(!wdt_reset_req && !rst_pin_drive, "R10", "no expiry after reset",
          {wdt_reset_req, rst_pin_drive}, 0);

    check(sb_q.size() == 0, "R2", "expected expiries never seen", sb_q.size(), 0);
    report();
  end

endmodule